// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides a fast input clock, which stands in for the oscillator or output-divider clock of a synthesizer loop, by a ratio whose long-run average is INT + FRAC/MOD. The integer part sets the base division. The fraction comes from a third-order noise-shaping sequence built from three cascaded accumulators that wrap modulo MOD. The modulus is programmable and does not have to be a power of two. On every divided period the sequence adds a small signed offset, between -3 and +4, to INT. The value actually loaded into the down-counter for that period is shown on `div_value`.

The lowest legal INT depends on the prescaler selection: 23 when `presc_sel` is 0 and 75 when it is 1. MOD must be at least 2, and FRAC must be below MOD. If any of these rules is broken, `cfg_bad` goes high and the counter keeps reusing its last divide value. An integer-mode bypass turns the dithering off. The synchronous `cnt_rst` holds the counter and clears the sequence state, so the system restarts the sequence at a known point after it changes the configuration. The block has no data stream. All pins are plain level controls and status, so no valid/ready handshake or back-pressure applies.

Top module: `fracn_fb_divider`

## Requirements
- R1: While `rst_n` is low, `div_clk` is 0 and `div_value` is 100 (parameter RST_DIV).
- R2: Each divided period begins with `div_clk` high for exactly one input cycle. At that point `div_value` shows the divide value for the period. The next `div_clk` pulse comes exactly `div_value` input cycles later.
- R3: In the k-th period after a counter reset (k = 1, 2, ...), `div_value` = INT + c1[k] + (c2[k] - c2[k-1]) + (c3[k] - 2·c3[k-1] + c3[k-2]). Here cX[j] is the carry of accumulator X on its j-th update, and cX[j] = 0 for j ≤ 0. Accumulator 1 adds FRAC, accumulator 2 adds the new value of accumulator 1, and accumulator 3 adds the new value of accumulator 2. All three start at 0 and wrap modulo MOD. The offset therefore lies in -3..+4.
- R4: With dithering active, any 6·MOD consecutive periods starting from period 2 or later span exactly 6·(MOD·INT + FRAC) input cycles.
- R5: `cfg_bad` is 1 exactly when one of these holds: INT < 23 with `presc_sel`=0; INT < 75 with `presc_sel`=1; MOD < 2; or FRAC ≥ MOD with `int_mode`=0. The boundary values INT=23, INT=75, MOD=2 and FRAC=MOD-1 are legal.
- R6: While `cfg_bad` is 1, every new period reloads the previous `div_value` unchanged.
- R7: With `int_mode`=1, every period uses `div_value` = INT, whatever FRAC is.
- R8: While `cnt_rst` is high, `div_clk` stays 0. In the first input cycle after `cnt_rst` falls, a new period starts (`div_clk` = 1), and the sequence restarts at period 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter hold and sequence clear |
| int_val | input | 16 | Integer part of the ratio |
| frac_val | input | 12 | Fraction numerator |
| mod_val | input | 12 | Fraction modulus |
| presc_sel | input | 1 | 0: low prescaler limit (23), 1: high limit (75) |
| int_mode | input | 1 | 1: integer division, no dithering |
| div_clk | output | 1 | One-cycle pulse at the start of each divided period |
| div_value | output | 17 | Divide value of the current period |
| cfg_bad | output | 1 | Configuration outside legal limits |

## Verification
The bench sweeps every FRAC for the small moduli and selected FRAC values for larger ones. It predicts each period's value from floor sums of the accumulated fractions, so a wrong accumulator chain or a wrong difference term shows up as a wrong per-period value. It also catches a modulus that wraps on a power of two instead of MOD, which breaks the 6·MOD window total. The legality limits are probed on both sides at 23/22, 75/74, MOD 2/1 and FRAC MOD-1/MOD. An off-by-one in any compare would either raise `cfg_bad` on a legal setting or let a new value through. Counter reset and integer mode are checked for the cycle of the first pulse and for FRAC having no effect, which catches a reload that is one cycle late or dithering that leaks into the bypass.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int OFS_W = 4;
  typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/fnd_acc_stage.sv
module fnd_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modv,
  output logic [W-1:0] sum_nxt,
  output logic         carry
);
  logic [W-1:0] acc;
  logic [W:0]   raw;

  always_comb begin
    raw     = {1'b0, acc} + {1'b0, addend};
    carry   = (raw >= {1'b0, modv});
    sum_nxt = carry ? W'(raw - {1'b0, modv}) : raw[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (step)   acc <= sum_nxt;
  end
endmodule

// File: rtl/fnd_noise_shaper.sv
module fnd_noise_shaper #(
  parameter int W      = 12,
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [W-1:0]  frac,
  input  logic [W-1:0]  modv,
  output fnd_pkg::ofs_t ofs
);
  localparam int OW = fnd_pkg::OFS_W;

  logic [W-1:0]      adds [STAGES];
  logic [W-1:0]      sums [STAGES];
  logic [STAGES-1:0] cy;
  logic              c2d, c3d, c3dd;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign adds[i] = frac;
    end else begin : g_chain
      assign adds[i] = sums[i-1];
    end
    fnd_acc_stage #(.W(W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
      .addend(adds[i]), .modv(modv), .sum_nxt(sums[i]), .carry(cy[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2d <= 1'b0; c3d <= 1'b0; c3dd <= 1'b0;
    end else if (clr) begin
      c2d <= 1'b0; c3d <= 1'b0; c3dd <= 1'b0;
    end else if (step) begin
      c2d <= cy[1]; c3d <= cy[2]; c3dd <= c3d;
    end
  end

  // first-order carry plus first and second differences, modulo 2^OW
  always_comb begin
    ofs = OW'({{(OW-1){1'b0}}, cy[0]} + {{(OW-1){1'b0}}, cy[1]}
            - {{(OW-1){1'b0}}, c2d} + {{(OW-1){1'b0}}, cy[2]}
            - {{(OW-2){1'b0}}, c3d, 1'b0} + {{(OW-1){1'b0}}, c3dd});
  end

  // R3
  ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ofs >= -4'sd3 && ofs <= 4'sd4));
endmodule

// File: rtl/fnd_cfg_check.sv
module fnd_cfg_check #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 12,
  parameter int MIN_LO = 23,
  parameter int MIN_HI = 75
) (
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              presc_sel,
  input  logic              int_mode,
  output logic              ok
);
  logic [INT_W-1:0] int_min;

  always_comb begin
    int_min = presc_sel ? INT_W'(MIN_HI) : INT_W'(MIN_LO);
    ok = (int_val >= int_min) && (mod_val >= FRAC_W'(2))
         && (int_mode || (frac_val < mod_val));
  end
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 12,
  parameter int MIN_LO  = 23,
  parameter int MIN_HI  = 75,
  parameter int RST_DIV = 100,
  localparam int DIV_W  = INT_W + 1,
  localparam int OW     = fnd_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_rst,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              presc_sel,
  input  logic              int_mode,
  output logic              div_clk,
  output logic [DIV_W-1:0]  div_value,
  output logic              cfg_bad
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] nxt_div;
  logic             cfg_ok;
  logic             load;
  logic             step;
  fnd_pkg::ofs_t    ofs;

  fnd_cfg_check #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_LO(MIN_LO), .MIN_HI(MIN_HI)) u_cfg (
    .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
    .presc_sel(presc_sel), .int_mode(int_mode), .ok(cfg_ok)
  );

  assign load = (cnt == '0) && !cnt_rst;
  assign step = load && cfg_ok && !int_mode;

  fnd_noise_shaper #(.W(FRAC_W)) u_shaper (
    .clk(clk), .rst_n(rst_n), .clr(cnt_rst), .step(step),
    .frac(frac_val), .modv(mod_val), .ofs(ofs)
  );

  always_comb begin
    if (!cfg_ok)       nxt_div = div_value;
    else if (int_mode) nxt_div = {1'b0, int_val};
    else               nxt_div = {1'b0, int_val} + {{(DIV_W-OW){ofs[OW-1]}}, ofs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      div_value <= DIV_W'(RST_DIV);
      div_clk   <= 1'b0;
    end else if (cnt_rst) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (load) begin
      cnt       <= nxt_div - DIV_W'(1);
      div_value <= nxt_div;
      div_clk   <= 1'b1;
    end else begin
      cnt     <= cnt - DIV_W'(1);
      div_clk <= 1'b0;
    end
  end

  assign cfg_bad = !cfg_ok;

  // period-length watch for the checks below
  logic [DIV_W-1:0] since;
  logic [DIV_W-1:0] last_n;
  logic             seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0; last_n <= '0; seen <= 1'b0;
    end else if (cnt_rst) begin
      since <= '0; seen <= 1'b0;
    end else if (div_clk) begin
      since <= DIV_W'(1); last_n <= div_value; seen <= 1'b1;
    end else begin
      since <= since + DIV_W'(1);
    end
  end

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n || cnt_rst)
    (div_clk && seen) |-> (since == last_n));
  // R6
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_ok) |=> $stable(div_value));
  // R7
  int_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_ok && int_mode) |=> (div_value == {1'b0, $past(int_val)}));
  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !div_clk);
endmodule

// File: tb/test_fracn_fb_divider.sv
module test_fracn_fb_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_rst;
  logic [15:0] int_val;
  logic [11:0] frac_val;
  logic [11:0] mod_val;
  logic        presc_sel;
  logic        int_mode;
  logic        div_clk;
  logic [16:0] div_value;
  logic        cfg_bad;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;
  longint last_exp;

  always #4 clk = ~clk;

  fracn_fb_divider i_fracn_fb_divider (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .int_val(int_val),
    .frac_val(frac_val), .mod_val(mod_val), .presc_sel(presc_sel),
    .int_mode(int_mode), .div_clk(div_clk), .div_value(div_value), .cfg_bad(cfg_bad)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // configure under counter reset; div_clk must stay low (R8)
  task automatic apply_cfg(input int iv, input int fr, input int md, input bit ps, input bit im);
    @(negedge clk);
    cnt_rst = 1'b1; int_val = 16'(iv); frac_val = 12'(fr); mod_val = 12'(md);
    presc_sel = ps; int_mode = im;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R8 pulse during cnt_rst", div_clk == 1'b0, div_clk, 0);
    end
    cnt_rst = 1'b0;
  endtask

  // run np periods, predicting each divide value from floor sums (R3)
  task automatic run_periods(input int iv, input int fr, input int md, input bit im,
                             input int np, input bit bad_exp);
    longint s1p = 0, s2p = 0, s3p = 0, t1 = 0, t2 = 0;
    int c2p = 0, c3p = 0, c3pp = 0;
    longint cyc = 0, start = 0, prev = 0, w0 = 0;
    int k = 0;
    bit win = !im && (np >= 6 * md + 2);
    while (k < np) begin
      @(negedge clk);
      cyc++;
      if (cyc > longint'(np + 2) * 300) begin
        chk("R2 watchdog on period", 1'b0, cyc, 0);
        return;
      end
      if (div_clk) begin
        longint s1, s2, s3, ex;
        int c1, c2, c3, y;
        k++;
        if (k == 1) begin
          chk("R8 first pulse cycle", cyc == 1, cyc, 1);
          chk("R5 cfg_bad", cfg_bad == bad_exp, cfg_bad, bad_exp);
        end else begin
          chk("R2 period length", (cyc - start) == prev, cyc - start, prev);
        end
        s1 = (longint'(k) * fr) / md;
        t1 += (longint'(k) * fr) % md;
        s2 = t1 / md;
        t2 += t1 % md;
        s3 = t2 / md;
        c1 = int'(s1 - s1p); c2 = int'(s2 - s2p); c3 = int'(s3 - s3p);
        y = c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
        s1p = s1; s2p = s2; s3p = s3; c2p = c2; c3pp = c3p; c3p = c3;
        ex = im ? iv : iv + y;
        if (im) chk("R7 integer mode value", div_value == ex, div_value, ex);
        else    chk("R3 divide value", div_value == ex, div_value, ex);
        prev = ex; start = cyc;
        if (win && k == 2) w0 = cyc;
        if (win && k == 6 * md + 2)
          chk("R4 6*MOD window total", (cyc - w0) == 6 * (longint'(md) * iv + fr),
              cyc - w0, 6 * (longint'(md) * iv + fr));
      end
    end
    last_exp = prev;
  endtask

  // invalid settings applied mid-run: value must repeat (R6) and cfg_bad set (R5)
  task automatic run_hold(input int iv, input int fr, input int md, input bit ps, input string tag);
    longint cyc = 0, start = 0;
    int k = 0;
    @(negedge clk);
    int_val = 16'(iv); frac_val = 12'(fr); mod_val = 12'(md); presc_sel = ps;
    #1;
    chk({"R5 cfg_bad ", tag}, cfg_bad == 1'b1, cfg_bad, 1);
    while (k < 3) begin
      @(negedge clk);
      cyc++;
      if (cyc > 2000) begin
        chk("R6 watchdog on hold", 1'b0, cyc, 0);
        return;
      end
      if (div_clk) begin
        k++;
        chk({"R6 held value ", tag}, div_value == last_exp, div_value, last_exp);
        if (k > 1) chk("R6 held period", (cyc - start) == last_exp, cyc - start, last_exp);
        start = cyc;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("R2 global watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    int mods[5] = '{2, 3, 5, 7, 11};
    rst_n = 1'b0; cnt_rst = 1'b1; int_val = 16'd30; frac_val = 12'd0; mod_val = 12'd5;
    presc_sel = 1'b0; int_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset div_clk", div_clk == 1'b0, div_clk, 0);
    chk("R1 reset div_value", div_value == 17'd100, div_value, 100);
    rst_n = 1'b1;

    // sweep: INT at the low prescaler minimum and a mid value
    for (int ii = 0; ii < 2; ii++) begin
      int iv = (ii == 0) ? 23 : 40;
      for (int mi = 0; mi < 5; mi++) begin
        int md = mods[mi];
        for (int fr = 0; fr < md; fr++) begin
          if (md > 5 && !(fr == 1 || fr == 3 || fr == md - 1)) continue;
          apply_cfg(iv, fr, md, 1'b0, 1'b0);
          run_periods(iv, fr, md, 1'b0, 6 * md + 3, 1'b0);
        end
      end
    end

    // high prescaler at its minimum
    apply_cfg(75, 1, 3, 1'b1, 1'b0);
    run_periods(75, 1, 3, 1'b0, 21, 1'b0);
    apply_cfg(90, 4, 7, 1'b1, 1'b0);
    run_periods(90, 4, 7, 1'b0, 44, 1'b0);

    // largest modulus, FRAC at MOD-1
    apply_cfg(30, 4094, 4095, 1'b0, 1'b0);
    run_periods(30, 4094, 4095, 1'b0, 24, 1'b0);

    // integer mode ignores FRAC
    apply_cfg(33, 3, 5, 1'b0, 1'b1);
    run_periods(33, 3, 5, 1'b1, 12, 1'b0);
    apply_cfg(24, 4000, 3, 1'b0, 1'b1);
    run_periods(24, 4000, 3, 1'b1, 6, 1'b0);

    // invalid settings: hold last value
    apply_cfg(30, 2, 5, 1'b0, 1'b0);
    run_periods(30, 2, 5, 1'b0, 7, 1'b0);
    run_hold(22, 2, 5, 1'b0, "INT 22 low");
    run_hold(74, 2, 5, 1'b1, "INT 74 high");
    run_hold(30, 0, 1, 1'b0, "MOD 1");
    run_hold(30, 5, 5, 1'b0, "FRAC=MOD");

    // long counter reset, then restart
    @(negedge clk);
    cnt_rst = 1'b1; int_val = 16'd28; frac_val = 12'd1; mod_val = 12'd2; presc_sel = 1'b0;
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (div_clk) hi++;
      end
      chk("R8 no pulse while held", hi == 0, hi, 0);
    end
    cnt_rst = 1'b0;
    run_periods(28, 1, 2, 1'b0, 14, 1'b0);

    finish_run();
  end
endmodule